// File: doc/BRIEF.md
# Add-in Card Slot Power-Up Sequencer

This block brings an add-in card slot up and down in a fixed order. After reset it keeps the main supply off, the reference clock off and the slot's active-low fundamental reset asserted for a discharge interval. It then enables the supply and waits for power-good. Next it enables the reference clock and waits for clock-stable. After a settle interval it releases the slot reset and polls the link-up status for a bounded time. Every interval is set in milliseconds and turned into clock cycles from a clock-frequency parameter. One down-counter times all the phases.

If a stability wait or the link poll times out, or an established link drops, the slot is torn down in reverse order: reset asserted, then clock off, then supply off, with a fixed delay after each step. A retry budget then starts the whole sequence again, beginning with a fresh discharge interval. When the budget is used up, the block parks in a sticky failed state. It leaves that state only on a reset or a start request. The three status inputs are asynchronous and each passes through a two-stage synchronizer.

Top module: `slot_pwr_seq`

## Requirements
- R1: While rst_ni is low, pwr_en_o, refclk_en_o, slot_rst_no, link_ready_o and failed_o are 0 and busy_o is 1.
- R2: Counting the first rising clock edge after reset release, or after the edge that enters the discharge phase, as edge 1, pwr_en_o rises at edge DISCH (DISCH = discharge time in cycles). All slot outputs stay off before that edge.
- R3: Let E be the edge where pwr_en_o rose and E+a the first edge that samples pwr_good_i high. If a+2 <= PG_TO, refclk_en_o rises at edge E+a+2. Otherwise teardown starts at edge E+PG_TO.
- R4: Let C be the edge where refclk_en_o rose and C+b the first edge that samples clk_stable_i high. If b+2 <= CS_TO, slot_rst_no rises at edge C+b+2+SETTLE. Otherwise teardown starts at edge C+CS_TO.
- R5: Let P be the edge where slot_rst_no rose and P+c the first edge that samples link_up_i high. If c+2 <= LINK_TO, link_ready_o rises at edge P+c+2.
- R6: If the link poll times out, slot_rst_no falls at edge P+LINK_TO. refclk_en_o falls OFF edges later and pwr_en_o falls 2*OFF edges after slot_rst_no. The phase after that starts another OFF edges later.
- R7: A teardown started by a supply or clock timeout keeps the same step timing as R6. An output that never turned on stays off throughout.
- R8: The sequence is retried MAX_RETRY times, each retry starting with the discharge phase. At the end of the last teardown, failed_o rises and stays high, all slot outputs stay off, and no new attempt starts.
- R9: start_i sampled high while failed_o is 1 clears failed_o at that edge and restarts from the discharge phase. start_i has no effect in any other state.
- R10: While the link is up, a link_up_i low first sampled at edge X makes link_ready_o and slot_rst_no fall at edge X+2. The R6 teardown and the retry policy then follow.
- R11: busy_o is 0 exactly while link_ready_o or failed_o is 1. link_ready_o is 1 only while slot_rst_no is 1.
- R12: refclk_en_o is never 1 while pwr_en_o is 0, and slot_rst_no is never 1 while refclk_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Restart request, honoured only in the failed state |
| pwr_good_i | input | 1 | Slot supply power-good, asynchronous |
| clk_stable_i | input | 1 | Reference clock stable, asynchronous |
| link_up_i | input | 1 | Link-up status, asynchronous |
| pwr_en_o | output | 1 | Main supply enable |
| refclk_en_o | output | 1 | Reference clock enable |
| slot_rst_no | output | 1 | Fundamental slot reset, active low |
| busy_o | output | 1 | Sequencing or tearing down |
| link_ready_o | output | 1 | Link is up and the slot is released |
| failed_o | output | 1 | Retry budget used up, sticky |

## Verification
Each result is due a fixed number of edges after its cause. A status input first sampled at some edge moves the slot outputs two edges later: one edge to finish synchronizing and one for the registered state. Timed phases last exactly their cycle count, measured from the edge that entered them. The bench's slot model raises each status input a chosen number of edges after the matching enable. The bench records the cycle index of every output change at the falling clock edge and compares it with a value computed from these latencies. It sweeps each latency across its timeout boundary, so that both the "just in time" case and the "one cycle late" case are checked.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

  typedef enum logic [3:0] {
    ST_DISCH,
    ST_PWR,
    ST_CLK,
    ST_SETTLE,
    ST_POLL,
    ST_UP,
    ST_TD_RST,
    ST_TD_CLK,
    ST_TD_PWR,
    ST_FAIL
  } seq_st_e;

  function automatic int unsigned ms_to_cyc(int unsigned hz, int unsigned ms);
    int unsigned c;
    c = (hz / 1000) * ms;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/slot_sync.sv
module slot_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/slot_dly_timer.sv
module slot_dly_timer #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= RST_VAL;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/slot_out_ctl.sv
module slot_out_ctl
  import slot_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  seq_st_e st_n_i,
  output logic    pwr_en_o,
  output logic    refclk_en_o,
  output logic    slot_rst_no
);

  // each enable set on entry to its up phase, cleared on its teardown step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_en_o    <= 1'b0;
      refclk_en_o <= 1'b0;
      slot_rst_no <= 1'b0;
    end else begin
      unique case (st_n_i)
        ST_PWR:    pwr_en_o    <= 1'b1;
        ST_CLK:    refclk_en_o <= 1'b1;
        ST_POLL:   slot_rst_no <= 1'b1;
        ST_TD_RST: slot_rst_no <= 1'b0;
        ST_TD_CLK: refclk_en_o <= 1'b0;
        ST_TD_PWR: pwr_en_o    <= 1'b0;
        ST_DISCH, ST_FAIL: begin
          pwr_en_o    <= 1'b0;
          refclk_en_o <= 1'b0;
          slot_rst_no <= 1'b0;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/slot_seq_fsm.sv
module slot_seq_fsm
  import slot_seq_pkg::*;
#(
  parameter int unsigned TW        = 8,
  parameter int unsigned DISCH_C   = 4,
  parameter int unsigned PG_C      = 4,
  parameter int unsigned CS_C      = 4,
  parameter int unsigned SETTLE_C  = 4,
  parameter int unsigned LINK_C    = 4,
  parameter int unsigned OFF_C     = 4,
  parameter int unsigned MAX_RETRY = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          pg_s_i,
  input  logic          cs_s_i,
  input  logic          lk_s_i,
  input  logic          tmr_done_i,
  output seq_st_e       st_q_o,
  output seq_st_e       st_n_o,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o
);

  localparam int unsigned RW = $clog2(MAX_RETRY + 2);

  seq_st_e       st_q, st_n;
  logic [RW-1:0] retry_q;
  logic          last_try;

  assign last_try = (retry_q == RW'(MAX_RETRY));

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_DISCH:  if (tmr_done_i) st_n = ST_PWR;
      ST_PWR: begin
        if (pg_s_i)          st_n = ST_CLK;
        else if (tmr_done_i) st_n = ST_TD_RST;
      end
      ST_CLK: begin
        if (cs_s_i)          st_n = ST_SETTLE;
        else if (tmr_done_i) st_n = ST_TD_RST;
      end
      ST_SETTLE: if (tmr_done_i) st_n = ST_POLL;
      ST_POLL: begin
        if (lk_s_i)          st_n = ST_UP;
        else if (tmr_done_i) st_n = ST_TD_RST;
      end
      ST_UP:     if (!lk_s_i) st_n = ST_TD_RST;
      ST_TD_RST: if (tmr_done_i) st_n = ST_TD_CLK;
      ST_TD_CLK: if (tmr_done_i) st_n = ST_TD_PWR;
      ST_TD_PWR: if (tmr_done_i) st_n = last_try ? ST_FAIL : ST_DISCH;
      ST_FAIL:   if (start_i) st_n = ST_DISCH;
      default:   st_n = ST_DISCH;
    endcase
  end

  // dwell of N cycles: load N-1 on entry
  always_comb begin
    tmr_load_o = (st_n != st_q);
    unique case (st_n)
      ST_DISCH:  tmr_val_o = TW'(DISCH_C - 1);
      ST_PWR:    tmr_val_o = TW'(PG_C - 1);
      ST_CLK:    tmr_val_o = TW'(CS_C - 1);
      ST_SETTLE: tmr_val_o = TW'(SETTLE_C - 1);
      ST_POLL:   tmr_val_o = TW'(LINK_C - 1);
      ST_TD_RST, ST_TD_CLK, ST_TD_PWR: tmr_val_o = TW'(OFF_C - 1);
      default:   tmr_val_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_DISCH;
      retry_q <= '0;
    end else begin
      st_q <= st_n;
      if (st_q == ST_TD_PWR && st_n == ST_DISCH) retry_q <= retry_q + 1'b1;
      else if (st_q == ST_FAIL && st_n == ST_DISCH) retry_q <= '0;
    end
  end

  assign st_q_o = st_q;
  assign st_n_o = st_n;

endmodule

// File: rtl/slot_pwr_seq.sv
module slot_pwr_seq
  import slot_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned DISCH_MS    = 100,
  parameter int unsigned PG_TO_MS    = 20,
  parameter int unsigned CS_TO_MS    = 20,
  parameter int unsigned SETTLE_MS   = 100,
  parameter int unsigned LINK_TO_MS  = 100,
  parameter int unsigned OFF_DLY_MS  = 10,
  parameter int unsigned MAX_RETRY   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic pwr_good_i,
  input  logic clk_stable_i,
  input  logic link_up_i,
  output logic pwr_en_o,
  output logic refclk_en_o,
  output logic slot_rst_no,
  output logic busy_o,
  output logic link_ready_o,
  output logic failed_o
);

  localparam int unsigned DISCH_C  = ms_to_cyc(CLK_HZ, DISCH_MS);
  localparam int unsigned PG_C     = ms_to_cyc(CLK_HZ, PG_TO_MS);
  localparam int unsigned CS_C     = ms_to_cyc(CLK_HZ, CS_TO_MS);
  localparam int unsigned SETTLE_C = ms_to_cyc(CLK_HZ, SETTLE_MS);
  localparam int unsigned LINK_C   = ms_to_cyc(CLK_HZ, LINK_TO_MS);
  localparam int unsigned OFF_C    = ms_to_cyc(CLK_HZ, OFF_DLY_MS);
  localparam int unsigned MAX_C    = umax(umax(umax(DISCH_C, PG_C), umax(CS_C, SETTLE_C)),
                                          umax(LINK_C, OFF_C));
  localparam int unsigned TW       = $clog2(MAX_C + 1);

  logic [2:0]    in_s;
  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  seq_st_e       st_q, st_n;

  slot_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({link_up_i, clk_stable_i, pwr_good_i}),
    .q_o    (in_s)
  );

  slot_dly_timer #(
    .W       (TW),
    .RST_VAL (TW'(DISCH_C - 1))
  ) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  slot_seq_fsm #(
    .TW        (TW),
    .DISCH_C   (DISCH_C),
    .PG_C      (PG_C),
    .CS_C      (CS_C),
    .SETTLE_C  (SETTLE_C),
    .LINK_C    (LINK_C),
    .OFF_C     (OFF_C),
    .MAX_RETRY (MAX_RETRY)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .pg_s_i     (in_s[0]),
    .cs_s_i     (in_s[1]),
    .lk_s_i     (in_s[2]),
    .tmr_done_i (tmr_done),
    .st_q_o     (st_q),
    .st_n_o     (st_n),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val)
  );

  slot_out_ctl u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .st_n_i      (st_n),
    .pwr_en_o    (pwr_en_o),
    .refclk_en_o (refclk_en_o),
    .slot_rst_no (slot_rst_no)
  );

  assign link_ready_o = (st_q == ST_UP);
  assign failed_o     = (st_q == ST_FAIL);
  assign busy_o       = !(link_ready_o || failed_o);

endmodule

// File: rtl/slot_pwr_seq_chk.sv
module slot_pwr_seq_chk
  import slot_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned DISCH_MS  = 100,
  parameter int unsigned SETTLE_MS = 100
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic pwr_en_o,
  input logic refclk_en_o,
  input logic slot_rst_no,
  input logic busy_o,
  input logic link_ready_o,
  input logic failed_o
);

  localparam int unsigned DISCH_C  = ms_to_cyc(CLK_HZ, DISCH_MS);
  localparam int unsigned SETTLE_C = ms_to_cyc(CLK_HZ, SETTLE_MS);

  int unsigned off_cnt, clk_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_cnt <= 0;
      clk_cnt <= 0;
    end else begin
      off_cnt <= pwr_en_o ? 0 : ((off_cnt == 32'hFFFF_FFFF) ? off_cnt : off_cnt + 1);
      clk_cnt <= !refclk_en_o ? 0 : ((clk_cnt == 32'hFFFF_FFFF) ? clk_cnt : clk_cnt + 1);
    end
  end

  // R12
  refclk_needs_pwr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refclk_en_o |-> pwr_en_o);

  // R12
  rst_rel_needs_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_rst_no |-> refclk_en_o);

  // R2
  discharge_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_en_o) |-> off_cnt >= DISCH_C);

  // R4
  settle_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slot_rst_no) |-> clk_cnt >= SETTLE_C);

  // R6
  td_clk_after_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(refclk_en_o) |-> !slot_rst_no);

  // R6
  td_pwr_after_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_en_o) |-> !refclk_en_o);

  // R11
  ready_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_ready_o |-> (!busy_o && slot_rst_no));

  // R8
  failed_all_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    failed_o |-> (!pwr_en_o && !refclk_en_o && !slot_rst_no && !busy_o));

  // R9
  failed_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (failed_o && !start_i) |=> failed_o);

endmodule

bind slot_pwr_seq slot_pwr_seq_chk #(
  .CLK_HZ    (CLK_HZ),
  .DISCH_MS  (DISCH_MS),
  .SETTLE_MS (SETTLE_MS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .pwr_en_o     (pwr_en_o),
  .refclk_en_o  (refclk_en_o),
  .slot_rst_no  (slot_rst_no),
  .busy_o       (busy_o),
  .link_ready_o (link_ready_o),
  .failed_o     (failed_o)
);

// File: tb/slot_pwr_seq_tb_top.sv
module slot_pwr_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int D   = 12;
  localparam int PGT = 8;
  localparam int CST = 6;
  localparam int S   = 10;
  localparam int L   = 15;
  localparam int O   = 4;
  localparam int R   = 2;
  localparam int NEVER = 1_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic pg = 1'b0, cs = 1'b0, lk = 1'b0;
  logic pwr_en, refclk_en, slot_rst_n, busy, rdy, failed;

  int cyc;
  int checks = 0;
  int fails = 0;
  int pg_lat = 1, cs_lat = 1, lk_lat = 1;
  int pg_cnt = 0, cs_cnt = 0, lk_cnt = 0;
  bit lk_kill = 1'b0;
  int nr_pwr, nr_clk, nr_rst, nr_rdy;
  logic p_pwr, p_clk, p_rst, p_rdy;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_pwr_seq #(
    .CLK_HZ     (1000),
    .DISCH_MS   (D),
    .PG_TO_MS   (PGT),
    .CS_TO_MS   (CST),
    .SETTLE_MS  (S),
    .LINK_TO_MS (L),
    .OFF_DLY_MS (O),
    .MAX_RETRY  (R)
  ) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .pwr_good_i   (pg),
    .clk_stable_i (cs),
    .link_up_i    (lk),
    .pwr_en_o     (pwr_en),
    .refclk_en_o  (refclk_en),
    .slot_rst_no  (slot_rst_n),
    .busy_o       (busy),
    .link_ready_o (rdy),
    .failed_o     (failed)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // slot model: each status input follows its enable after a set number of edges
  always @(negedge clk) begin
    if (!pwr_en) begin pg_cnt = 0; pg = 1'b0; end
    else begin pg_cnt++; pg = (pg_cnt >= pg_lat); end
    if (!refclk_en) begin cs_cnt = 0; cs = 1'b0; end
    else begin cs_cnt++; cs = (cs_cnt >= cs_lat); end
    if (!slot_rst_n || lk_kill) begin lk_cnt = 0; lk = 1'b0; end
    else begin lk_cnt++; lk = (lk_cnt >= lk_lat); end
  end

  // rise counters, updated just after each edge
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      nr_pwr = 0; nr_clk = 0; nr_rst = 0; nr_rdy = 0;
    end else begin
      if (pwr_en && !p_pwr)     nr_pwr++;
      if (refclk_en && !p_clk)  nr_clk++;
      if (slot_rst_n && !p_rst) nr_rst++;
      if (rdy && !p_rdy)        nr_rdy++;
    end
    p_pwr = pwr_en; p_clk = refclk_en; p_rst = slot_rst_n; p_rdy = rdy;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic get_out(int sel);
    case (sel)
      0: return pwr_en;
      1: return refclk_en;
      2: return slot_rst_n;
      3: return rdy;
      default: return failed;
    endcase
  endfunction

  task automatic wait_out(int sel, logic val, output int t);
    while (get_out(sel) !== val) @(negedge clk);
    t = cyc;
  endtask

  task automatic do_reset(int a, int b, int c);
    @(negedge clk);
    rst_n = 1'b0;
    lk_kill = 1'b0;
    pg_lat = a; cs_lat = b; lk_lat = c;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (R1..R12 run): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int t, e, er, x0, y;
    // full attempt length from supply enable to end of teardown, with a=b=1 and no link
    int att;
    att = 3 + 3 + S + L + 3*O;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {pwr_en, refclk_en, slot_rst_n, busy, rdy, failed}, 6'b000100);
    rst_n = 1'b1;

    // R9 start ignored during discharge; R2 all off before edge D
    repeat (5) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (D - 7) @(negedge clk);
    chk("R2", {pwr_en, refclk_en, slot_rst_n}, 3'b000);
    wait_out(0, 1'b1, t);
    chk("R9", t, D);
    wait_out(1, 1'b1, t);
    chk("R3", t, D + 3);
    wait_out(2, 1'b1, t);
    chk("R4", t, D + 6 + S);
    wait_out(3, 1'b1, t);
    chk("R5", t, D + 9 + S);
    chk("R11", busy, 0);

    // R10 link drop
    repeat (5) @(negedge clk);
    x0 = cyc;
    #1 lk_kill = 1'b1;
    wait_out(3, 1'b0, t);
    chk("R10", t, x0 + 4);
    chk("R10", slot_rst_n, 0);
    chk("R11", busy, 1);
    wait_out(0, 1'b0, t);
    chk("R10", t, x0 + 4 + 2*O);
    lk_kill = 1'b0;
    wait_out(0, 1'b1, t);
    chk("R10", t, x0 + 4 + 3*O + D);
    e = t;
    wait_out(3, 1'b1, t);
    chk("R10", t, e + 9 + S);

    // R3/R7 sweep over power-good latency
    for (int a = 1; a <= PGT + 1; a++) begin
      do_reset(a, 1, 1);
      wait_out(0, 1'b1, t);
      chk("R2", t, D);
      if (a + 2 <= PGT) begin
        wait_out(1, 1'b1, t);
        chk("R3", t, D + a + 2);
      end else begin
        wait_out(0, 1'b0, t);
        chk("R7", t, D + PGT + 2*O);
        chk("R7", nr_clk, 0);
      end
    end

    // R4/R7 sweep over clock-stable latency
    for (int b = 1; b <= CST + 1; b++) begin
      do_reset(1, b, 1);
      wait_out(1, 1'b1, t);
      chk("R3", t, D + 3);
      if (b + 2 <= CST) begin
        wait_out(2, 1'b1, t);
        chk("R4", t, D + 3 + b + 2 + S);
      end else begin
        wait_out(1, 1'b0, t);
        chk("R7", t, D + 3 + CST + O);
        wait_out(0, 1'b0, t);
        chk("R7", t, D + 3 + CST + 2*O);
        chk("R7", nr_rst, 0);
      end
    end

    // R5/R6 sweep over link latency
    for (int c = 1; c <= L + 1; c++) begin
      do_reset(1, 1, c);
      wait_out(2, 1'b1, t);
      er = D + 6 + S;
      chk("R4", t, er);
      if (c + 2 <= L) begin
        wait_out(3, 1'b1, t);
        chk("R5", t, er + c + 2);
      end else begin
        wait_out(2, 1'b0, t);
        chk("R6", t, er + L);
        wait_out(1, 1'b0, t);
        chk("R6", t, er + L + O);
        wait_out(0, 1'b0, t);
        chk("R6", t, er + L + 2*O);
        chk("R6", nr_rdy, 0);
        wait_out(0, 1'b1, t);
        chk("R6", t, er + L + 3*O + D);
      end
    end

    // R8 retries then sticky failure
    do_reset(1, 1, NEVER);
    wait_out(4, 1'b1, t);
    chk("R8", t, D + R*(att + D) + att);
    chk("R8", nr_pwr, R + 1);
    chk("R11", busy, 0);
    repeat (30) @(negedge clk);
    chk("R8", {failed, pwr_en, refclk_en, slot_rst_n}, 4'b1000);
    chk("R8", nr_pwr, R + 1);

    // R9 start leaves the failed state
    lk_lat = 1;
    y = cyc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", failed, 0);
    chk("R11", busy, 1);
    wait_out(0, 1'b1, t);
    chk("R9", t, y + 1 + D);
    wait_out(3, 1'b1, t);
    chk("R9", t, y + 1 + D + 9 + S);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule